// File: doc/BRIEF.md
# Serial EEPROM Command Front End (three-wire slave)

This block is the slave-side instruction engine of a three-wire serial memory in the Microwire style, with 16-bit words and an 8-bit word address. Each instruction is framed by chip select. The block hunts for a start bit and collects two opcode bits and the address. From the opcode, the protection-enable input and the top address bits it picks one of eleven instructions. Memory reads stream out on the serial output. Memory writes are gathered and committed to a simple register-array model when chip select drops at the right moment. Protection-register instructions are passed to a separate protection unit as a one-cycle request.

All inputs are synchronous to the system clock. Serial clock edges are found by comparing each sample with the previous one. The write-enable latch is held inside the block and is cleared by reset. A host drives chip select high while the serial clock is low. It then clocks in start, opcode, address and any data. For reads it keeps clocking to receive words.

Top module: `mw_eeprom_front`

## Requirements
- R1: An instruction begins only when chip select rises while the serial clock is low. Zeros sampled before the first '1' are ignored. If chip select rises while the serial clock is high, the whole selection is ignored.
- R2: With protection-enable low, opcode 10 is read, 01 is single write and 11 is page write. Opcode 00 takes the two top address bits as an extension: 01 is fill-all, 11 is write enable and 00 is write disable.
- R3: A read drives a 0 on the rising edge that samples the last address bit. Each later rising edge drives the next bit of the addressed word, MSB first. The serial output changes only on a serial clock rise, or to 0 on deselect. The array holds zeros after reset.
- R4: While chip select stays high, the read continues with the next address and no dummy bit. The address wraps from 0xFF to 0x00.
- R5: Writes are disabled after reset. Write enable sets the latch and write disable clears it. Reads are not affected by the latch.
- R6: A write-type instruction takes effect only if the W input was high at chip select rise and stayed high until the commit.
- R7: A single write is 27 serial clocks. It commits only if chip select falls after the 16th data bit and before any further serial clock rise.
- R8: A page write accepts 1 to 4 words. The word address advances in its two low bits only (0x2E, 0x2F, 0x2C). All words commit together on the same deselect window as R7.
- R9: Fill-all writes its single data word to every location.
- R10: With protection-enable high, the decoded instruction gives a one-cycle prot_req with a prot_op code and the 8-bit address. The codes are: 10 → read (code 0); 01 → register write (code 1); 11 with address 0xFF → clear (code 2); 00 with top bits 11 → enable (code 3); 00 with address 0x00 → disable/lock (code 4). Codes 1 to 4 need the write latch set and W high.
- R11: sdo_oe equals chip select. A chip select fall in the middle of an instruction aborts it with no effect, and the next instruction decodes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset (power-on) |
| cs | input | 1 | Chip select |
| sck | input | 1 | Serial clock, sampled by clk |
| sdi | input | 1 | Serial data in |
| wr_allow | input | 1 | W pin, must be high for writes |
| pre_sel | input | 1 | Protection-register select |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo |
| prot_req | output | 1 | One-cycle protection request |
| prot_op | output | 3 | Protection operation code |
| prot_addr | output | 8 | Address carried with the request |

## Verification
The assertions assume that cs, sck, sdi, wr_allow and pre_sel are already synchronous to clk. They also assume each serial clock level lasts at least one clk cycle, so that every rise is seen exactly once. The bench drives all pins just after a falling clk edge and holds each serial clock phase for two clk cycles. It keeps pre_sel stable through the whole instruction, because the decoder samples it when the last address bit arrives. Commit checks rely on the bench lowering sck before it drops chip select.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [2:0] {ST_OFF, ST_HUNT, ST_OPC, ST_ADR, ST_RD, ST_DAT, ST_ARM, ST_SINK} mw_state_e;
  typedef enum logic [1:0] {WM_ONE, WM_PAGE, WM_ALL} wmode_e;
  typedef enum logic [2:0] {PC_RD = 3'd0, PC_WR = 3'd1, PC_CLR = 3'd2, PC_EN = 3'd3, PC_DIS = 3'd4} pcode_e;
  typedef struct packed {
    logic   hit;
    pcode_e code;
  } pdec_t;

  // protection-side decode from opcode, top address bits and all-ones/all-zeros flags
  function automatic pdec_t prot_decode(input logic [1:0] op, input logic [1:0] top,
                                        input logic all1, input logic all0);
    pdec_t r;
    r.hit  = 1'b0;
    r.code = PC_RD;
    case (op)
      2'b10: r.hit = 1'b1;
      2'b01: begin r.hit = 1'b1; r.code = PC_WR; end
      2'b11: begin r.hit = all1; r.code = PC_CLR; end
      default: begin
        if (top == 2'b11) begin r.hit = 1'b1; r.code = PC_EN; end
        else if (all0)    begin r.hit = 1'b1; r.code = PC_DIS; end
      end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/mw_edge.sv
module mw_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sck,
  output logic sck_rise,
  output logic cs_rise,
  output logic cs_fall
);
  logic sck_q, cs_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b0;
    end else begin
      sck_q <= sck;
      cs_q  <= cs;
    end
  end
  assign sck_rise = sck & ~sck_q;
  assign cs_rise  = cs & ~cs_q;
  assign cs_fall  = ~cs & cs_q;
endmodule

// File: rtl/mw_wel.sv
module mw_wel (
  input  logic clk,
  input  logic rst_n,
  input  logic set_en,
  input  logic clr_en,
  output logic wel
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wel <= 1'b0;
    else if (clr_en) wel <= 1'b0;
    else if (set_en) wel <= 1'b1;
  end
endmodule

// File: rtl/mw_array.sv
module mw_array
  import mw_pkg::*;
#(
  parameter int AW   = 8,
  parameter int DW   = 16,
  parameter int PAGE = 4,
  localparam int PW  = (PAGE > 1) ? $clog2(PAGE) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     commit,
  input  wmode_e                   mode,
  input  logic [AW-1:0]            base,
  input  logic [PAGE-1:0][DW-1:0]  words,
  input  logic [PW:0]              nwords,
  input  logic [AW-1:0]            rd_addr,
  output logic [DW-1:0]            rd_data
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  // page slot j: only the low PW address bits advance
  function automatic logic [AW-1:0] slot(input logic [AW-1:0] b, input int j);
    logic [AW-1:0] r;
    r = b;
    r[PW-1:0] = b[PW-1:0] + PW'(j);
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (commit) begin
      case (mode)
        WM_ALL:  for (int i = 0; i < DEPTH; i++) mem[i] <= words[0];
        WM_PAGE: for (int j = 0; j < PAGE; j++)
                   if ((PW+1)'(j) < nwords) mem[slot(base, j)] <= words[j];
        default: mem[base] <= words[0];
      endcase
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/mw_eeprom_front.sv
module mw_eeprom_front
  import mw_pkg::*;
#(
  parameter int AW   = 8,
  parameter int DW   = 16,
  parameter int PAGE = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          sck,
  input  logic          sdi,
  input  logic          wr_allow,
  input  logic          pre_sel,
  output logic          sdo,
  output logic          sdo_oe,
  output logic          prot_req,
  output logic [2:0]    prot_op,
  output logic [AW-1:0] prot_addr
);
  localparam int PW = (PAGE > 1) ? $clog2(PAGE) : 1;
  localparam int CW = $clog2(DW) + 1;

  mw_state_e st;
  logic [CW-1:0] cnt;
  logic [1:0] op;
  logic [AW-1:0] adr, ptr, base, full_adr, rd_addr;
  logic [DW-1:0] dsh, rsh, rd_data;
  logic [PAGE-1:0][DW-1:0] wbuf;
  logic [PW:0] widx;
  wmode_e wmode;
  logic w_ok, sdo_q, wel, prot_req_q;
  logic [2:0] prot_op_q;
  logic [AW-1:0] prot_addr_q;
  logic sck_rise, cs_rise, cs_fall;
  logic adr_done, rd_load, rd_next, wel_set_ev, wel_clr_ev, p_fire, commit;
  logic [1:0] ext;
  pdec_t pd;

  mw_edge u_edge (.clk(clk), .rst_n(rst_n), .cs(cs), .sck(sck),
                  .sck_rise(sck_rise), .cs_rise(cs_rise), .cs_fall(cs_fall));

  mw_wel u_wel (.clk(clk), .rst_n(rst_n), .set_en(wel_set_ev), .clr_en(wel_clr_ev), .wel(wel));

  mw_array #(.AW(AW), .DW(DW), .PAGE(PAGE)) u_arr (
    .clk(clk), .rst_n(rst_n), .commit(commit), .mode(wmode), .base(base),
    .words(wbuf), .nwords(widx), .rd_addr(rd_addr), .rd_data(rd_data));

  // named decode events, visible to the assertions
  always_comb begin
    full_adr   = {adr[AW-2:0], sdi};
    ext        = full_adr[AW-1 -: 2];
    adr_done   = cs && (st == ST_ADR) && sck_rise && (cnt == CW'(AW-1));
    rd_load    = adr_done && !pre_sel && (op == 2'b10);
    rd_next    = cs && (st == ST_RD) && sck_rise && (cnt == CW'(DW-1));
    wel_set_ev = adr_done && !pre_sel && (op == 2'b00) && (ext == 2'b11);
    wel_clr_ev = adr_done && !pre_sel && (op == 2'b00) && (ext == 2'b00);
    pd         = prot_decode(op, ext, &full_adr, ~|full_adr);
    p_fire     = adr_done && pre_sel && pd.hit &&
                 ((pd.code == PC_RD) || (wel && w_ok && wr_allow));
    rd_addr    = (st == ST_RD) ? ptr + AW'(1) : full_adr;
    commit     = (st == ST_ARM) && cs_fall && wel && w_ok && wr_allow;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_OFF; cnt <= '0; op <= '0; adr <= '0; ptr <= '0; base <= '0;
      dsh <= '0; rsh <= '0; wbuf <= '0; widx <= '0; wmode <= WM_ONE;
      w_ok <= 1'b0; sdo_q <= 1'b0;
      prot_req_q <= 1'b0; prot_op_q <= '0; prot_addr_q <= '0;
    end else begin
      prot_req_q <= p_fire;
      if (p_fire) begin
        prot_op_q   <= pd.code;
        prot_addr_q <= full_adr;
      end
      if (!cs) begin
        st <= ST_OFF; sdo_q <= 1'b0; cnt <= '0;
      end else if (cs_rise) begin
        st   <= sck ? ST_SINK : ST_HUNT;
        w_ok <= wr_allow;
        widx <= '0;
        cnt  <= '0;
      end else begin
        if (!wr_allow) w_ok <= 1'b0;
        if (sck_rise) begin
          case (st)
            ST_HUNT: if (sdi) begin st <= ST_OPC; cnt <= '0; end
            ST_OPC: begin
              op <= {op[0], sdi};
              if (cnt == CW'(1)) begin st <= ST_ADR; cnt <= '0; end
              else cnt <= cnt + 1'b1;
            end
            ST_ADR: begin
              adr <= full_adr;
              if (adr_done) begin
                cnt  <= '0;
                base <= full_adr;
                st   <= ST_SINK;
                if (!pre_sel) begin
                  case (op)
                    2'b10: begin st <= ST_RD; ptr <= full_adr; rsh <= rd_data; sdo_q <= 1'b0; end
                    2'b01: begin st <= ST_DAT; wmode <= WM_ONE; end
                    2'b11: begin st <= ST_DAT; wmode <= WM_PAGE; end
                    default: if (ext == 2'b01) begin st <= ST_DAT; wmode <= WM_ALL; end
                  endcase
                end
              end else cnt <= cnt + 1'b1;
            end
            ST_RD: begin
              sdo_q <= rsh[DW-1];
              if (rd_next) begin
                cnt <= '0; ptr <= ptr + AW'(1); rsh <= rd_data;
              end else begin
                cnt <= cnt + 1'b1; rsh <= {rsh[DW-2:0], 1'b0};
              end
            end
            ST_DAT: begin
              dsh <= {dsh[DW-2:0], sdi};
              if (cnt == CW'(DW-1)) begin
                wbuf[widx[PW-1:0]] <= {dsh[DW-2:0], sdi};
                widx <= widx + 1'b1;
                st   <= ST_ARM;
              end else cnt <= cnt + 1'b1;
            end
            ST_ARM: begin
              if ((wmode == WM_PAGE) && (widx < (PW+1)'(PAGE))) begin
                dsh <= {dsh[DW-2:0], sdi}; cnt <= CW'(1); st <= ST_DAT;
              end else st <= ST_SINK;
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign sdo       = sdo_q;
  assign sdo_oe    = cs;
  assign prot_req  = prot_req_q;
  assign prot_op   = prot_op_q;
  assign prot_addr = prot_addr_q;

  // commit only at deselect with the latch set (R7, R5)
  assert_commit_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (cs_fall && wel));
  // serial output moves only on a serial clock rise while selected (R3)
  assert_sdo_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && !sck_rise) |=> $stable(sdo_q));
  // dummy zero precedes read data (R3)
  assert_dummy_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_load |=> (sdo_q == 1'b0));
  // sequential read advances by one, wrapping (R4)
  assert_read_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_next |=> (ptr == $past(ptr) + AW'(1)));
  // deselect aborts (R11)
  assert_abort_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> (st == ST_OFF));
  // write disable leaves the latch clear (R5)
  assert_wds_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr_ev |=> !wel);
  // gated protection requests need the latch (R10)
  assert_prot_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (p_fire && pd.code != PC_RD) |-> (wel && wr_allow));
endmodule

// File: tb/mw_eeprom_front_tb_top.sv
module mw_eeprom_front_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs = 1'b0, sck = 1'b0, sdi = 1'b0, wr_allow = 1'b1, pre_sel = 1'b0;
  logic sdo, sdo_oe, prot_req;
  logic [2:0] prot_op;
  logic [7:0] prot_addr;
  int total = 0, bad = 0;
  int model_mem [256];
  int prot_cnt = 0;
  int last_op = -1, last_addr = -1;

  always #5 clk = ~clk;

  mw_eeprom_front dut_i (.clk(clk), .rst_n(rst_n), .cs(cs), .sck(sck), .sdi(sdi),
    .wr_allow(wr_allow), .pre_sel(pre_sel), .sdo(sdo), .sdo_oe(sdo_oe),
    .prot_req(prot_req), .prot_op(prot_op), .prot_addr(prot_addr));

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison of the output enable against chip select (R11)
  always @(posedge clk) if (rst_n) begin
    total++;
    if (sdo_oe !== cs) begin bad++; $display("FAIL R11 oe actual=%b expected=%b", sdo_oe, cs); end
  end

  always @(negedge clk) if (prot_req) begin
    prot_cnt++; last_op = int'(prot_op); last_addr = int'(prot_addr);
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic sbit(input logic b, output logic q);
    sdi = b; sck = 1'b0; tick(); tick();
    sck = 1'b1; tick(); q = sdo; tick();
  endtask

  task automatic send(input logic [63:0] v, input int n);
    logic q;
    for (int i = n - 1; i >= 0; i--) sbit(v[i], q);
  endtask

  task automatic sel(); sck = 1'b0; cs = 1'b1; tick(); tick(); endtask
  task automatic desel(); sck = 1'b0; tick(); cs = 1'b0; tick(); tick(); endtask

  task automatic wr(input logic [1:0] op, input logic [7:0] a, input logic [15:0] d);
    sel(); send({37'd0, 1'b1, op, a, d}, 27); desel();
  endtask

  task automatic cmd(input logic pre, input logic [1:0] op, input logic [7:0] a);
    pre_sel = pre; sel(); send({53'd0, 1'b1, op, a}, 11); desel(); pre_sel = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input int n);
    logic q;
    logic [15:0] w;
    sel(); send({54'd0, 1'b1, 2'b10, a[7:1]}, 10);
    sbit(a[0], q);
    chk({tag, " dummy R3"}, int'(q), 0);
    for (int k = 0; k < n; k++) begin
      w = '0;
      for (int b = 0; b < 16; b++) begin sbit(1'b0, q); w = {w[14:0], q}; end
      chk(tag, int'(w), model_mem[(int'(a) + k) % 256]);
    end
    desel();
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic q;
    int pc;
    for (int i = 0; i < 256; i++) model_mem[i] = 0;
    tick(); tick();
    chk("R11 reset oe", int'(sdo_oe), 0);
    chk("R3 reset sdo", int'(sdo), 0);
    chk("R10 reset prot_req", int'(prot_req), 0);
    rst_n = 1'b1; tick();

    rd("R3 zero after reset", 8'h05, 1);
    // R5: write with latch clear is dropped
    wr(2'b01, 8'h10, 16'hA5C3);
    rd("R5 no write while disabled", 8'h10, 1);
    // R2/R7: write enable then single write
    cmd(1'b0, 2'b00, 8'hC0);
    wr(2'b01, 8'h10, 16'hA5C3); model_mem[16'h10] = 16'hA5C3;
    rd("R7 single write", 8'h10, 1);
    // R6: W pin dropped mid instruction
    sel(); send({37'd0, 1'b1, 2'b01, 8'h11, 16'h0000} >> 8, 19);
    wr_allow = 1'b0; send(64'h0055, 8); wr_allow = 1'b1; desel();
    rd("R6 W low blocks write", 8'h11, 1);
    // R7: extra clock after the data misses the window
    sel(); send({36'd0, 1'b1, 2'b01, 8'h11, 16'h1234, 1'b0}, 28); desel();
    rd("R7 late deselect ignored", 8'h11, 1);
    // R11: abort mid data, then a clean write
    sel(); send({37'd0, 1'b1, 2'b01, 8'h12, 16'hFFFF} >> 7, 20); desel();
    rd("R11 abort leaves location", 8'h12, 1);
    wr(2'b01, 8'h12, 16'hBEEF); model_mem[16'h12] = 16'hBEEF;
    rd("R11 next instruction ok", 8'h12, 1);
    // R1: leading zeros before the start bit
    sel(); send({34'd0, 3'b000, 1'b1, 2'b01, 8'h13, 16'h0F0F}, 30); desel();
    model_mem[16'h13] = 16'h0F0F;
    rd("R1 leading zeros ignored", 8'h13, 1);
    // R1: chip select rising with the clock high
    sck = 1'b1; tick(); cs = 1'b1; tick(); tick();
    send({37'd0, 1'b1, 2'b01, 8'h14, 16'h7777}, 27); desel();
    rd("R1 bad select ignored", 8'h14, 1);
    // R4: wrap across the top address
    wr(2'b01, 8'hFF, 16'h8001); model_mem[255] = 16'h8001;
    wr(2'b01, 8'h00, 16'h4002); model_mem[0] = 16'h4002;
    wr(2'b01, 8'hFE, 16'h2003); model_mem[254] = 16'h2003;
    rd("R4 sequential wrap", 8'hFE, 4);
    // R8: page write of 3 words from 0x2E
    sel(); send({53'd0, 1'b1, 2'b11, 8'h2E}, 11);
    send(64'h1111, 16); send(64'h2222, 16); send(64'h3333, 16); desel();
    model_mem[16'h2E] = 16'h1111; model_mem[16'h2F] = 16'h2222; model_mem[16'h2C] = 16'h3333;
    rd("R8 page slot 0", 8'h2E, 2);
    rd("R8 page roll to 0x2C", 8'h2C, 1);
    chk("R8 0x30 untouched", model_mem[16'h30], 0);
    rd("R8 next page unchanged", 8'h30, 1);
    // R10: protection decodes
    pc = prot_cnt; cmd(1'b1, 2'b10, 8'h00);
    chk("R10 read req", prot_cnt - pc, 1); chk("R10 read code", last_op, 0);
    pc = prot_cnt; cmd(1'b1, 2'b01, 8'h40);
    chk("R10 write code", last_op, 1); chk("R10 write addr", last_addr, 8'h40);
    pc = prot_cnt; cmd(1'b1, 2'b11, 8'hFF); chk("R10 clear code", last_op, 2);
    pc = prot_cnt; cmd(1'b1, 2'b11, 8'hFE); chk("R10 clear needs ones", prot_cnt - pc, 0);
    pc = prot_cnt; cmd(1'b1, 2'b00, 8'hC5); chk("R10 enable code", last_op, 3);
    pc = prot_cnt; cmd(1'b1, 2'b00, 8'h00); chk("R10 lock code", last_op, 4);
    chk("R10 lock count", prot_cnt - pc, 1);
    // R9: fill all
    sel(); send({37'd0, 1'b1, 2'b00, 8'h40, 16'h5A5A}, 27); desel();
    for (int i = 0; i < 256; i++) model_mem[i] = 16'h5A5A;
    rd("R9 fill all low", 8'h00, 2);
    rd("R9 fill all high", 8'hFF, 1);
    rd("R9 fill all mid", 8'h80, 1);
    // R5: write disable; reads still work, writes and gated requests dropped
    cmd(1'b0, 2'b00, 8'h00);
    wr(2'b01, 8'h80, 16'h0001);
    rd("R5 read after disable", 8'h80, 1);
    pc = prot_cnt; cmd(1'b1, 2'b01, 8'h41);
    chk("R10 gated by latch", prot_cnt - pc, 0);
    pc = prot_cnt; cmd(1'b1, 2'b10, 8'h00);
    chk("R10 read not gated", prot_cnt - pc, 1);
    // R2: unused extension 10 does nothing
    cmd(1'b0, 2'b00, 8'hC0);
    sel(); send({37'd0, 1'b1, 2'b00, 8'h80, 16'h0000}, 27); desel();
    rd("R2 reserved extension", 8'h00, 1);
    finish_up();
  end
endmodule